// File: doc/BRIEF.md
# Row-Column Organized Mask ROM

A fixed-content read-only memory of 256 words, 4 bits each, built as a 32 by 32 cell matrix rather than a flat word table. The low five address bits drive a row decoder that raises one of 32 row lines. The high three address bits steer four 8-to-1 column selectors, one per output bit, so the word is gathered from four separate column groups of the chosen row.

The cell contents are computed at elaboration from a closed-form rule, so the matrix needs no stored table. The read path has no clock. Two active-low chip selects enable the output drivers. When either select is high, all four outputs float.

Top module: `mrom_32x32`

## Requirements
- R1: The block takes an 8-bit address and returns a 4-bit word, giving 256 distinct addresses.
- R2: Address bits 4:0 select exactly one of 32 row lines, and the row index equals the value on those bits.
- R3: Output bit k is taken from column 8k + addr[7:5] of the selected row. Cell (row r, column 8k+c) holds bit k of the word at address c*32 + r.
- R4: For address a, with lo = a[3:0], hi = a[7:4] and rot = {lo[2:0], lo[3]}, the stored word is lo ^ hi ^ rot.
- R5: When cs0_ni and cs1_ni are both 0, data_o drives the stored word on all four bits, with no Z or X bit.
- R6: When cs0_ni or cs1_ni is 1, all four bits of data_o are high-impedance.
- R7: The read is combinational. A new address shows its word with no clock edge in between.
- R8: Address changes while the block is deselected have no effect: data_o stays all Z, and the next select shows the word for the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 8 | Word address; bits 4:0 pick the row, bits 7:5 pick the column |
| cs0_ni | input | 1 | Chip select 0, active low |
| cs1_ni | input | 1 | Chip select 1, active low |
| data_o | output | 4 | Read data, high-impedance when deselected |

## Verification
The bench reads all 256 addresses. A row decoder that swaps or drops a row bit, or a column selector fed from the wrong group, returns a word that does not match the formula for some address. Each of the four chip-select combinations is tried at several addresses. Gating on a single select, or on an OR instead of an AND of the enables, shows up as driven bits where Z is expected, or Z where data is expected. Addresses are also changed while the block is deselected, and the bench then checks that the first selected read shows the current word and not a stale one.

// File: rtl/mrom_pkg.sv
package mrom_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 4;
  localparam int ROW_W  = 5;
  localparam int COL_W  = ADDR_W - ROW_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int SPAN   = 1 << COL_W;
  localparam int COLS   = DATA_W * SPAN;

  // R4 content rule
  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] lo, hi, rot;
    lo  = a[DATA_W-1:0];
    hi  = DATA_W'(a >> DATA_W);
    rot = {lo[DATA_W-2:0], lo[DATA_W-1]};
    return lo ^ hi ^ rot;
  endfunction

  // Cells of one physical column, one bit per row
  function automatic logic [ROWS-1:0] col_image(input int col);
    logic [ROWS-1:0]   m;
    logic [DATA_W-1:0] w;
    int k, c;
    k = col / SPAN;
    c = col % SPAN;
    for (int r = 0; r < ROWS; r++) begin
      w    = word_at(ADDR_W'(c * ROWS + r));
      m[r] = w[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/mrom_row_dec.sv
module mrom_row_dec #(
  parameter int ROW_W = mrom_pkg::ROW_W,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic [ROW_W-1:0] row_idx_i,
  output logic [ROWS-1:0]  row_line_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_line_o[r] = (row_idx_i == ROW_W'(r));
  end
endmodule

// File: rtl/mrom_cell_array.sv
module mrom_cell_array #(
  parameter int ROWS = mrom_pkg::ROWS,
  parameter int COLS = mrom_pkg::COLS
) (
  input  logic [ROWS-1:0] row_line_i,
  output logic [COLS-1:0] col_o
);
  // Wired-OR per column: a stored 1 pulls the column high when its row is up
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [ROWS-1:0] TIES = mrom_pkg::col_image(c);
    assign col_o[c] = |(row_line_i & TIES);
  end
endmodule

// File: rtl/mrom_col_sel.sv
module mrom_col_sel #(
  parameter int DATA_W = mrom_pkg::DATA_W,
  parameter int COL_W  = mrom_pkg::COL_W,
  localparam int SPAN  = 1 << COL_W,
  localparam int COLS  = DATA_W * SPAN
) (
  input  logic [COLS-1:0]   col_i,
  input  logic [COL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] bit_o
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    logic [SPAN-1:0] grp;
    assign grp      = col_i[k*SPAN +: SPAN];
    assign bit_o[k] = grp[sel_i];
  end
endmodule

// File: rtl/mrom_32x32.sv
module mrom_32x32
  import mrom_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs0_ni,
  input  logic              cs1_ni,
  output logic [DATA_W-1:0] data_o
);
  logic [ROWS-1:0]   row_line;
  logic [COLS-1:0]   col_bus;
  logic [DATA_W-1:0] word;
  logic              drive_en;

  mrom_row_dec #(.ROW_W(ROW_W)) i_row_dec (
    .row_idx_i (addr_i[ROW_W-1:0]),
    .row_line_o(row_line)
  );

  mrom_cell_array #(.ROWS(ROWS), .COLS(COLS)) i_cells (
    .row_line_i(row_line),
    .col_o     (col_bus)
  );

  mrom_col_sel #(.DATA_W(DATA_W), .COL_W(COL_W)) i_col_sel (
    .col_i(col_bus),
    .sel_i(addr_i[ADDR_W-1:ROW_W]),
    .bit_o(word)
  );

  assign drive_en = ~cs0_ni & ~cs1_ni;
  assign data_o   = drive_en ? word : {DATA_W{1'bz}};

  always_comb begin
    if (!$isunknown(addr_i)) begin
      a_r2_row_onehot: assert ($onehot(row_line));
      a_r2_row_index:  assert (row_line[addr_i[ROW_W-1:0]]);
      a_r3_word_rule:  assert (word == word_at(addr_i));
    end
    if (!$isunknown({cs0_ni, cs1_ni})) begin
      if (cs0_ni || cs1_ni) begin
        a_r6_float: assert (data_o === {DATA_W{1'bz}});
      end else if (!$isunknown(addr_i)) begin
        a_r5_driven: assert (!$isunknown(data_o));
      end
    end
  end
endmodule

// File: tb/test_mrom_32x32.sv
module test_mrom_32x32;
  logic       clk = 1'b0;
  logic [7:0] addr_i = '0;
  logic       cs0_ni = 1'b1;
  logic       cs1_ni = 1'b1;
  logic [3:0] data_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] addr;
    logic [3:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  mrom_32x32 i_mrom_32x32 (
    .addr_i(addr_i),
    .cs0_ni(cs0_ni),
    .cs1_ni(cs1_ni),
    .data_o(data_o)
  );

  function automatic logic [3:0] ref_word(input logic [7:0] a);
    logic [3:0] lo;
    lo = a[3:0];
    return lo ^ a[7:4] ^ {lo[2:0], lo[3]};
  endfunction

  task automatic drive(input logic [7:0] a, input logic c0, input logic c1, input string req);
    item_t it;
    @(posedge clk);
    addr_i = a;
    cs0_ni = c0;
    cs1_ni = c1;
    it.addr = a;
    it.req  = req;
    it.exp  = (!c0 && !c1) ? ref_word(a) : 4'bzzzz;
    sb_q.push_back(it);
  endtask

  // Monitor: one compare per cycle, away from the driving edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (data_o !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%02h actual=%b expected=%b", it.req, it.addr, data_o, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Idle state: deselected, outputs float (R6)
    drive(8'h00, 1'b1, 1'b1, "R6_idle");
    // Chip-select combinations at several addresses (R5, R6)
    foreach (sb_q[i]) ;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h00 : (i == 1) ? 8'h5A : (i == 2) ? 8'hA7 : 8'hFF;
      drive(a, 1'b1, 1'b1, "R6_both_high");
      drive(a, 1'b0, 1'b1, "R6_cs1_high");
      drive(a, 1'b1, 1'b0, "R6_cs0_high");
      drive(a, 1'b0, 1'b0, "R5_selected");
    end
    // Full sweep, new address every cycle (R1, R2, R3, R4, R7)
    for (int a = 0; a < 256; a++) drive(8'(a), 1'b0, 1'b0, "R3_R4_sweep");
    // Row and column walking patterns (R2, R3)
    for (int r = 0; r < 5; r++) drive(8'(1 << r), 1'b0, 1'b0, "R2_row_bit");
    for (int c = 5; c < 8; c++) drive(8'(1 << c), 1'b0, 1'b0, "R3_col_bit");
    // Address moves while deselected (R8)
    drive(8'h11, 1'b1, 1'b0, "R8_desel_a");
    drive(8'h3C, 1'b1, 1'b0, "R8_desel_b");
    drive(8'hE2, 1'b0, 1'b1, "R8_desel_c");
    drive(8'hE2, 1'b0, 1'b0, "R8_reselect");
    drive(8'h1D, 1'b0, 1'b0, "R7_next_addr");
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule